// File: doc/BRIEF.md
# Reshapeable Two-Clock Block Memory

This block holds 2,304 bits behind one write port and one read port. Each port has its own clock. A two-bit organisation input chooses how the storage appears to both ports: a few wide words or many narrow ones. Both ports always carry a 10-bit address and an 18-bit data bus. The organisation decides how many low address bits select a word and how many low data bits carry it.

Writes always happen on the write clock. The read port has two styles. The first is a registered read, loaded on the read clock while the read enable is high. The second is a flow-through read, in which the enable gates the addressed word straight onto the output. Software or surrounding logic sets the organisation once and leaves it fixed.

When a write and a read hit the same word in the same cycle, the read returns the data being written. This holds in both read styles. Internally, each organisation packs its words side by side into 128 rows of 18 bits. Words that share a row but are not written keep their contents.

Top module: `cfg_dpram`

## Requirements
- R1: The organisation input `org` selects the shape: value 0 gives 128 words of 18 bits, 1 gives 256 words of 9 bits, 2 gives 512 words of 4 bits, and 3 gives 1024 words of 2 bits. Every word keeps whatever was last written to it.
- R2: The word index is the lowest 7, 8, 9 or 10 address bits, for organisations 0 to 3. Address bits above the index are ignored on both ports.
- R3: A word occupies the low bits of the data buses. Write data bits above the word width are ignored, and read data bits above the word width are always 0.
- R4: A write takes effect on the rising edge of `wr_clk` only when `wr_en` is 1. With `wr_en` at 0 the memory contents do not change.
- R5: With `rd_flow` at 0 and `rd_en` at 1, the word at `rd_addr` appears on `rd_data` after the rising edge of `rd_clk`.
- R6: With `rd_flow` at 0 and `rd_en` at 0, `rd_data` keeps its previous value across the `rd_clk` edge.
- R7: With `rd_flow` at 1 and `rd_en` at 1, `rd_data` shows the addressed word combinationally, with no clock edge needed.
- R8: With `rd_flow` at 1 and `rd_en` at 0, `rd_data` is 0.
- R9: If a write and a read select the same word in the same cycle, the read returns the new data, in both read styles. A read of a different word in the same internal row returns that word's stored value.
- R10: While `rst` is sampled 1 on a `rd_clk` edge, the registered read value is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| org | input | 2 | Organisation select (0: 128x18, 1: 256x9, 2: 512x4, 3: 1024x2) |
| wr_clk | input | 1 | Write port clock |
| wr_en | input | 1 | Write enable, used as a clock enable |
| wr_addr | input | 10 | Write address; low bits index the word |
| wr_data | input | 18 | Write data; low bits carry the word |
| rd_clk | input | 1 | Read port clock |
| rst | input | 1 | Synchronous active-high reset of the read register (read clock domain) |
| rd_en | input | 1 | Read enable: clock enable when registered, output gate when flow-through |
| rd_flow | input | 1 | 1 selects flow-through read, 0 selects registered read |
| rd_addr | input | 10 | Read address |
| rd_data | output | 18 | Read data; bits above the word width are 0 |

## Verification
The hardest case to reach is a same-cycle collision in the narrow organisations. In those modes a write and a read can land in the same internal row while naming either the same word or a neighbouring one. Each case has a different correct answer. Random addresses over the full range almost never collide. The stimulus therefore often reuses the write address for the read, often confines both addresses to a small window, and adds directed pairs at the first and last word and at adjacent words in both read styles.

// File: rtl/cfg_dpram_pkg.sv
package cfg_dpram_pkg;

  // Organisation codes seen on the org input
  typedef enum logic [1:0] {
    ORG_W18 = 2'd0,
    ORG_W9  = 2'd1,
    ORG_W4  = 2'd2,
    ORG_W2  = 2'd3
  } org_e;

  // Width of one word for a given organisation: the full bus shifted down
  function automatic int lane_width(input int data_w, input logic [1:0] org);
    return data_w >> org;
  endfunction

endpackage

// File: rtl/cfg_dpram_map.sv
// Turns a port address into a storage row, a bit offset inside the row
// and an unshifted mask of the live word bits.
module cfg_dpram_map #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [1:0]        org,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-4:0] row,
  output logic [SH_W-1:0]   shift,
  output logic [DATA_W-1:0] mask
);
  import cfg_dpram_pkg::*;

  logic [ADDR_W-1:0] above;
  logic [ADDR_W-1:0] lane;
  int                lane_w;

  always_comb begin
    lane_w = lane_width(DATA_W, org);
    above  = addr >> org;
    row    = above[ADDR_W-4:0];
    lane   = addr & ((ADDR_W'(1) << org) - ADDR_W'(1));
    shift  = SH_W'(int'(lane) * lane_w);
    mask   = (DATA_W'(1) << lane_w) - DATA_W'(1);
  end

endmodule

// File: rtl/cfg_dpram_store.sv
// Row storage with a per-bit write mask; one write port, one read port.
module cfg_dpram_store #(
  parameter int ROW_W  = 7,
  parameter int DATA_W = 18,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_bits,
  input  logic [DATA_W-1:0] wr_bmask,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (wr_bmask[b]) mem[wr_row][b] <= wr_bits[b];
      end
    end
  end

  assign rd_word = mem[rd_row];

endmodule

// File: rtl/cfg_dpram_rdpath.sv
// Same-cycle write forwarding, lane extraction and the two read styles.
module cfg_dpram_rdpath #(
  parameter int DATA_W = 18,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_flow,
  input  logic [DATA_W-1:0] row_word,
  input  logic              fwd_hit,
  input  logic [DATA_W-1:0] fwd_bits,
  input  logic [DATA_W-1:0] fwd_bmask,
  input  logic [SH_W-1:0]   rd_shift,
  input  logic [DATA_W-1:0] rd_mask,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] lane_val;
  logic [DATA_W-1:0] held_q;

  always_comb begin
    merged   = fwd_hit ? ((row_word & ~fwd_bmask) | (fwd_bits & fwd_bmask)) : row_word;
    lane_val = (merged >> rd_shift) & rd_mask;
  end

  always_ff @(posedge rd_clk) begin
    if (rst)                   held_q <= '0;
    else if (rd_en && !rd_flow) held_q <= lane_val;
  end

  assign rd_data = rd_flow ? (rd_en ? lane_val : '0) : held_q;

endmodule

// File: rtl/cfg_dpram.sv
module cfg_dpram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic [1:0]        org,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_flow,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int ROW_W = ADDR_W - 3;
  localparam int SH_W  = $clog2(DATA_W);

  logic [ROW_W-1:0]  w_row, r_row;
  logic [SH_W-1:0]   w_shift, r_shift;
  logic [DATA_W-1:0] w_mask, r_mask;
  logic [DATA_W-1:0] w_bits, w_bmask;
  logic [DATA_W-1:0] row_word;
  logic              fwd_hit;

  cfg_dpram_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SH_W(SH_W)) u_wmap (
    .org(org), .addr(wr_addr), .row(w_row), .shift(w_shift), .mask(w_mask)
  );

  cfg_dpram_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SH_W(SH_W)) u_rmap (
    .org(org), .addr(rd_addr), .row(r_row), .shift(r_shift), .mask(r_mask)
  );

  assign w_bits  = (wr_data & w_mask) << w_shift;
  assign w_bmask = w_mask << w_shift;
  assign fwd_hit = wr_en && (w_row == r_row);

  cfg_dpram_store #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_store (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_row(w_row), .wr_bits(w_bits),
    .wr_bmask(w_bmask), .rd_row(r_row), .rd_word(row_word)
  );

  cfg_dpram_rdpath #(.DATA_W(DATA_W), .SH_W(SH_W)) u_rd (
    .rd_clk(rd_clk), .rst(rst), .rd_en(rd_en), .rd_flow(rd_flow),
    .row_word(row_word), .fwd_hit(fwd_hit), .fwd_bits(w_bits),
    .fwd_bmask(w_bmask), .rd_shift(r_shift), .rd_mask(r_mask),
    .rd_data(rd_data)
  );

endmodule

// File: rtl/cfg_dpram_chk.sv
module cfg_dpram_chk #(
  parameter int DATA_W = 18
) (
  input logic              rd_clk,
  input logic              rst,
  input logic [1:0]        org,
  input logic              rd_en,
  input logic              rd_flow,
  input logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] live;
  assign live = (DATA_W'(1) << (DATA_W >> org)) - DATA_W'(1);

  AST_UPPER_ZERO: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_data & ~live) == '0); // R3

  AST_FLOW_GATED: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_flow && !rd_en) |-> rd_data == '0); // R8

  AST_SYNC_HOLD: assert property (@(posedge rd_clk) disable iff (rst)
    (!rd_flow && !rd_en) |=> (rd_flow || $stable(rd_data))); // R6

  AST_RESET_CLEAR: assert property (@(posedge rd_clk)
    rst |=> (rd_flow || rd_data == '0)); // R10

endmodule

bind cfg_dpram cfg_dpram_chk #(.DATA_W(DATA_W)) u_chk (
  .rd_clk(rd_clk), .rst(rst), .org(org), .rd_en(rd_en),
  .rd_flow(rd_flow), .rd_data(rd_data)
);

// File: tb/sim_cfg_dpram.sv
module sim_cfg_dpram;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  org;
  logic        wr_en, rd_en, rd_flow, rst;
  logic [9:0]  wr_addr, rd_addr;
  logic [17:0] wr_data;
  logic [17:0] rd_data;

  cfg_dpram u0 (
    .org(org), .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(clk), .rst(rst), .rd_en(rd_en), .rd_flow(rd_flow),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int          checks = 0;
  int          errors = 0;
  int          m_cur  = 0;
  logic [17:0] refm [1024];
  logic [17:0] exp_q = '0;
  logic        cur_flow = 1'b0;
  string       sync_tag = "R10";
  bit          done = 0;

  function automatic int depth_of(input int m);
    return 128 << m;
  endfunction

  function automatic logic [17:0] wmask(input int m);
    return 18'((1 << (18 >> m)) - 1);
  endfunction

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (org %0d)", tag, act, exp, m_cur);
    end
  endtask

  task automatic step(input logic we, input logic [9:0] wa, input logic [17:0] wd,
                      input logic re, input logic [9:0] ra, input logic fl,
                      input string tag);
    int          wi, ri;
    logic [17:0] e;
    string       t;
    bit          coll;
    @(negedge clk);
    if (!cur_flow) chk(sync_tag, rd_data, exp_q);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra; rd_flow = fl;
    cur_flow = fl;
    wi   = int'(wa) & (depth_of(m_cur) - 1);
    ri   = int'(ra) & (depth_of(m_cur) - 1);
    coll = we && re && (wi == ri);
    if (tag != "")                          t = tag;
    else if (!re)                           t = fl ? "R8" : "R6";
    else if (coll)                          t = "R9";
    else if ((int'(ra) >> (7 + m_cur)) != 0) t = "R2";
    else                                    t = fl ? "R7" : "R5";
    #1;
    if (fl) begin
      e = re ? (coll ? (wd & wmask(m_cur)) : refm[ri]) : 18'h0;
      chk(t, rd_data, e);
      chk("R3", rd_data & ~wmask(m_cur), 18'h0);
    end
    @(posedge clk);
    #1;
    if (we) refm[wi] = wd & wmask(m_cur);
    if (re && !fl) exp_q = refm[ri];
    sync_tag = t;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; rd_flow = 1'b0; cur_flow = 1'b0;
    @(posedge clk);
    #1 exp_q = '0;
    @(negedge clk);
    rst = 1'b0;
    chk("R10", rd_data, 18'h0);
    sync_tag = "R10";
  endtask

  function automatic logic [9:0] junk_hi(input int a, input int m);
    return 10'((a & (depth_of(m) - 1)) | ($urandom & ~(depth_of(m) - 1)));
  endfunction

  initial begin
    void'($urandom(32'd1729));
    org = 2'd0; rst = 1'b1; wr_en = 0; rd_en = 0; rd_flow = 0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    for (int m = 0; m < 4; m++) begin
      org = 2'(m); m_cur = m;
      do_reset();
      // R4: fill every word, upper address and data bits randomised
      for (int a = 0; a < depth_of(m); a++)
        step(1'b1, junk_hi(a, m), 18'($urandom), 1'b0, 10'd0, 1'b0, "");
      // R1: read back every word, alternating read styles
      for (int a = 0; a < depth_of(m); a++)
        step(1'b0, 10'd0, 18'h0, 1'b1, (a < depth_of(m) / 2) ? 10'(a) : junk_hi(a, m),
             1'(a & 1), (a < depth_of(m) / 2) ? "R1" : "");
      // R4: disabled write leaves word 0 unchanged
      step(1'b0, 10'd0, ~refm[0], 1'b1, 10'd0, 1'b0, "R4");
      step(1'b0, 10'd0, 18'h0, 1'b1, 10'd0, 1'b1, "R4");
      // R9: collisions at first and last word, both styles
      step(1'b1, 10'd0, 18'($urandom), 1'b1, 10'd0, 1'b0, "R9");
      step(1'b1, 10'(depth_of(m) - 1), 18'($urandom), 1'b1, 10'(depth_of(m) - 1), 1'b1, "R9");
      step(1'b1, 10'(depth_of(m) - 1), 18'($urandom), 1'b1, 10'(depth_of(m) - 1), 1'b0, "R9");
      // R9: neighbour word in the same row is not disturbed
      if (m > 0) begin
        step(1'b1, 10'd2, 18'($urandom), 1'b1, 10'd3, 1'b0, "R9");
        step(1'b1, 10'd4, 18'($urandom), 1'b1, 10'd5, 1'b1, "R9");
      end
      // Random mix with a narrow address window to force collisions
      for (int n = 0; n < 500; n++) begin
        logic [9:0] wa, ra;
        wa = 10'($urandom) & (($urandom % 2 == 0) ? 10'h00F : 10'h3FF);
        ra = ($urandom % 3 == 0) ? wa : (10'($urandom) & 10'h00F);
        step(1'($urandom), wa, 18'($urandom), 1'($urandom), ra, 1'($urandom), "");
      end
    end
    step(1'b0, 10'd0, 18'h0, 1'b0, 10'd0, 1'b0, "");
    @(negedge clk);
    if (!cur_flow) chk(sync_tag, rd_data, exp_q);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule